// File: doc/BRIEF.md
# CPU Hotplug Register Block

This block is a small memory-mapped register window through which a guest (firmware or an operating system) finds and manages hot-pluggable CPUs on a multi-CPU platform. Each CPU slot has three pieces of state: a present flag, a pending-event flag, and a 64-bit architecture ID. The platform side loads this state through a configuration write port.

The block leaves reset in legacy mode. In that mode, a read of offset 0x0 returns a bitmap of present CPUs. A single write to the selector offset moves it, for good, into modern mode. Modern mode is a command interface: a CPU selector, a command register, and two command-data read registers. Firmware can tell the two modes apart from reads alone. A fresh block reads bit 0 set at offset 0x0, because CPU 0 is always present. After one write of zero to the selector, the same offset reads zero. The command set has two commands: fetch the selected CPU's ID, and move the selector to the next CPU that has a pending event.

The bus side is a plain register interface. A write takes effect at the clock edge on which `bus_wr_en` is high. Read data is a combinational function of `bus_rd_addr` and the current state. There is no handshake and no back-pressure, so every access completes in one cycle.

Top module: `cpu_hotplug_regs`

## Requirements
- R1: After reset the block is in legacy mode. A read of offset 0x0 returns the present-CPU bitmap, with bit n standing for CPU n. Only bit 0 is set until the configuration port adds CPUs.
- R2: In legacy mode, any write to offset 0x4 (the selector) switches the block permanently to modern mode and leaves the selector at 0. In legacy mode, writes to any other offset are ignored and do not switch the mode.
- R3: In modern mode, offset 0x0 (command data 2) reads 0 while the selector value is not below NUM_CPUS.
- R4: In modern mode, offset 0x0 reads 0 while the last accepted command (bits [7:0] of the write to 0x0C) is not 3. After the mode switch, the last command is 0.
- R5: With command 3 and a valid selector, offset 0x0 reads bits [63:32] of the selected CPU's ID and offset 0x8 reads bits [31:0].
- R6: Writing command 0 with a valid selector moves the selector to the first CPU with a pending event. The search runs upward from selector+1, wraps at NUM_CPUS, and checks the selector itself last. If no CPU has an event, the selector is unchanged. While the last command is 0 and the selector is valid, offset 0x8 reads the selector value.
- R7: A write to offset 0x0C while the selector is invalid is ignored: the last command and the selector keep their values.
- R8: Reads of offsets with no defined meaning return 0. In legacy mode that is every offset except 0x0. In modern mode it is every offset other than 0x0, 0x4 and 0x8, and 0x8 when the last command is neither 0 nor 3.
- R9: A configuration write sets the present flag, event flag and 64-bit ID of the addressed CPU. The present flag of CPU 0 cannot be cleared.
- R10: In modern mode, offset 0x4 reads the selected CPU's present flag in bit 0 and its event flag in bit 1. It reads 0 when the selector is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 4 | Write byte offset |
| bus_wr_data | input | 32 | Write data |
| bus_rd_addr | input | 4 | Read byte offset |
| bus_rd_data | output | 32 | Combinational read data |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_cpu | input | IDX_W | CPU index for a configuration write |
| cfg_present | input | 1 | Present flag to store |
| cfg_event | input | 1 | Pending-event flag to store |
| cfg_arch_id | input | 64 | Architecture ID to store |

## Verification
The hardest situation to reach is a command arriving at a moment when the selector has just been written to an invalid index, after an earlier get-ID command. Only then does ignoring the command show up as stale command-2 data once the selector becomes valid again. The random stream therefore picks the invalid selector range often and interleaves it with command writes. A directed sequence also builds that exact order. The wrap-around of the event search is reached by placing events at indices below the selector and by cases with no event at all.

// File: rtl/cpu_hp_pkg.sv
package cpu_hp_pkg;
  localparam logic [3:0] OFS_DATA2 = 4'h0;
  localparam logic [3:0] OFS_SEL   = 4'h4;
  localparam logic [3:0] OFS_DATA  = 4'h8;
  localparam logic [3:0] OFS_CMD   = 4'hC;
  localparam logic [7:0] CMD_NEXT_EVENT = 8'd0;
  localparam logic [7:0] CMD_GET_ID     = 8'd3;
  localparam int ID_W = 64;
endpackage

// File: rtl/hp_cpu_table.sv
module hp_cpu_table #(
  parameter int NUM_CPUS = 32,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_cpu,
  input  logic                 wr_present,
  input  logic                 wr_event,
  input  logic [63:0]          wr_id,
  input  logic [IDX_W-1:0]     rd_cpu,
  output logic [NUM_CPUS-1:0]  present_vec,
  output logic [NUM_CPUS-1:0]  event_vec,
  output logic [63:0]          rd_id
);
  logic [NUM_CPUS-1:0] present_q;
  logic [NUM_CPUS-1:0] event_q;
  logic [63:0]         id_q [NUM_CPUS];

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        present_q[g] <= (g == 0);
        event_q[g]   <= 1'b0;
        id_q[g]      <= '0;
      end else if (wr_en && int'(wr_cpu) == g) begin
        present_q[g] <= (g == 0) ? 1'b1 : wr_present;
        event_q[g]   <= wr_event;
        id_q[g]      <= wr_id;
      end
    end
  end

  assign present_vec = present_q;
  assign event_vec   = event_q;
  assign rd_id       = (int'(rd_cpu) < NUM_CPUS) ? id_q[rd_cpu] : '0;

  assert_cpu0_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_cpu == '0 |=> present_q[0]);
endmodule

// File: rtl/hp_event_scan.sv
module hp_event_scan #(
  parameter int NUM_CPUS = 32,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic [NUM_CPUS-1:0] events,
  input  logic [IDX_W-1:0]    start,
  output logic                found,
  output logic [IDX_W-1:0]    hit
);
  always_comb begin
    found = 1'b0;
    hit   = start;
    for (int k = 1; k <= NUM_CPUS; k++) begin
      automatic int pos = int'(start) + k;
      if (pos >= NUM_CPUS) pos = pos - NUM_CPUS;
      if (!found && events[pos]) begin
        found = 1'b1;
        hit   = pos[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    if (found) begin
      assert_scan_hit_R6: assert (events[hit]);
    end
  end
endmodule

// File: rtl/cpu_hotplug_regs.sv
module cpu_hotplug_regs
  import cpu_hp_pkg::*;
#(
  parameter int NUM_CPUS = 32,
  localparam int IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_en,
  input  logic [3:0]       bus_wr_addr,
  input  logic [31:0]      bus_wr_data,
  input  logic [3:0]       bus_rd_addr,
  output logic [31:0]      bus_rd_data,
  input  logic             cfg_wr_en,
  input  logic [IDX_W-1:0] cfg_cpu,
  input  logic             cfg_present,
  input  logic             cfg_event,
  input  logic [63:0]      cfg_arch_id
);
  logic                modern_q;
  logic [31:0]         sel_q;
  logic [7:0]          cmd_q;
  logic                sel_ok;
  logic [IDX_W-1:0]    sel_idx;
  logic [NUM_CPUS-1:0] present_vec;
  logic [NUM_CPUS-1:0] event_vec;
  logic [63:0]         sel_id;
  logic                scan_found;
  logic [IDX_W-1:0]    scan_hit;
  logic                wr_sel;
  logic                wr_cmd;

  assign sel_ok  = sel_q < 32'(NUM_CPUS);
  assign sel_idx = sel_q[IDX_W-1:0];
  assign wr_sel  = bus_wr_en && bus_wr_addr == OFS_SEL;
  assign wr_cmd  = bus_wr_en && bus_wr_addr == OFS_CMD;

  hp_cpu_table #(.NUM_CPUS(NUM_CPUS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_cpu(cfg_cpu), .wr_present(cfg_present),
    .wr_event(cfg_event), .wr_id(cfg_arch_id),
    .rd_cpu(sel_idx), .present_vec(present_vec), .event_vec(event_vec),
    .rd_id(sel_id)
  );

  hp_event_scan #(.NUM_CPUS(NUM_CPUS)) u_scan (
    .events(event_vec), .start(sel_idx), .found(scan_found), .hit(scan_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modern_q <= 1'b0;
      sel_q    <= '0;
      cmd_q    <= CMD_NEXT_EVENT;
    end else if (!modern_q) begin
      if (wr_sel) modern_q <= 1'b1;
    end else if (wr_sel) begin
      sel_q <= bus_wr_data;
    end else if (wr_cmd && sel_ok) begin
      cmd_q <= bus_wr_data[7:0];
      if (bus_wr_data[7:0] == CMD_NEXT_EVENT && scan_found)
        sel_q <= 32'(scan_hit);
    end
  end

  always_comb begin
    bus_rd_data = '0;
    if (!modern_q) begin
      if (bus_rd_addr == OFS_DATA2) bus_rd_data[NUM_CPUS-1:0] = present_vec;
    end else if (sel_ok) begin
      unique case (bus_rd_addr)
        OFS_DATA2: if (cmd_q == CMD_GET_ID) bus_rd_data = sel_id[63:32];
        OFS_SEL:   bus_rd_data = {30'd0, event_vec[sel_idx], present_vec[sel_idx]};
        OFS_DATA: begin
          if (cmd_q == CMD_GET_ID)          bus_rd_data = sel_id[31:0];
          else if (cmd_q == CMD_NEXT_EVENT) bus_rd_data = sel_q;
        end
        default: bus_rd_data = '0;
      endcase
    end
  end

  assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    modern_q |=> modern_q);
  assert_legacy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !modern_q && !wr_sel |=> !modern_q);
  assert_bad_sel_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    modern_q && wr_cmd && !sel_ok |=> $stable(cmd_q) && $stable(sel_q));
  assert_data2_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    modern_q && !sel_ok && bus_rd_addr == OFS_DATA2 |-> bus_rd_data == 32'd0);
endmodule

// File: tb/cpu_hotplug_regs_tb.sv
module cpu_hotplug_regs_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_wr_addr = '0;
  logic [31:0] bus_wr_data = '0;
  logic [3:0]  bus_rd_addr = '0;
  logic [31:0] bus_rd_data;
  logic        cfg_wr_en = 1'b0;
  logic [4:0]  cfg_cpu = '0;
  logic        cfg_present = 1'b0;
  logic        cfg_event = 1'b0;
  logic [63:0] cfg_arch_id = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // bench model
  bit          m_modern;
  logic [31:0] m_sel;
  logic [7:0]  m_cmd;
  logic [31:0] m_pres;
  logic [31:0] m_ev;
  logic [63:0] m_id [N];

  cpu_hotplug_regs #(.NUM_CPUS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
    .bus_wr_data(bus_wr_data), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
    .cfg_wr_en(cfg_wr_en), .cfg_cpu(cfg_cpu), .cfg_present(cfg_present),
    .cfg_event(cfg_event), .cfg_arch_id(cfg_arch_id)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] a);
    bit ok = m_sel < N;
    if (!m_modern) return (a == 4'h0) ? m_pres : 32'd0;
    if (!ok) return 32'd0;
    case (a)
      4'h0: return (m_cmd == 8'd3) ? m_id[m_sel[4:0]][63:32] : 32'd0;
      4'h4: return {30'd0, m_ev[m_sel[4:0]], m_pres[m_sel[4:0]]};
      4'h8: return (m_cmd == 8'd3) ? m_id[m_sel[4:0]][31:0] :
                   (m_cmd == 8'd0) ? m_sel : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_for(logic [3:0] a);
    if (!m_modern) return (a == 4'h0) ? "R1" : "R8";
    if (m_sel >= N) return (a == 4'h0) ? "R3" : "R8";
    case (a)
      4'h0: return (m_cmd == 8'd3) ? "R5" : "R4";
      4'h4: return "R10";
      4'h8: return (m_cmd == 8'd3) ? "R5" : (m_cmd == 8'd0) ? "R6" : "R8";
      default: return "R8";
    endcase
  endfunction

  function automatic void model_write(logic [3:0] a, logic [31:0] d);
    if (!m_modern) begin
      if (a == 4'h4) m_modern = 1;
    end else if (a == 4'h4) begin
      m_sel = d;
    end else if (a == 4'hC && m_sel < N) begin
      m_cmd = d[7:0];
      if (m_cmd == 8'd0) begin
        for (int k = 1; k <= N; k++) begin
          int p = (int'(m_sel) + k) % N;
          if (m_ev[p]) begin m_sel = 32'(p); break; end
        end
      end
    end
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic cfg_write(int cpu, bit pres, bit ev, logic [63:0] id);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_cpu = cpu[4:0]; cfg_present = pres; cfg_event = ev; cfg_arch_id = id;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_pres[cpu] = (cpu == 0) ? 1'b1 : pres;
    m_ev[cpu] = ev;
    m_id[cpu] = id;
  endtask

  task automatic read_check(logic [3:0] a, string tag);
    bus_rd_addr = a;
    #1;
    check(tag, bus_rd_data, exp_read(a));
  endtask

  task automatic read_auto(logic [3:0] a);
    string t = tag_for(a);
    read_check(a, t);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_modern = 0; m_sel = 0; m_cmd = 0; m_pres = 32'd1; m_ev = 0;
    for (int i = 0; i < N; i++) m_id[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, bit 0 only
    bus_rd_addr = 4'h0; #1;
    check("R1", bus_rd_data, 32'd1);
    read_check(4'h8, "R8");
    // R9: cannot clear CPU 0 present
    cfg_write(0, 1'b0, 1'b0, 64'h1111_2222_3333_4444);
    read_check(4'h0, "R9");
    cfg_write(5, 1'b1, 1'b0, 64'hA5A5_0005_5A5A_0005);
    cfg_write(9, 1'b1, 1'b1, 64'hDEAD_0009_BEEF_0009);
    read_check(4'h0, "R9");
    // R2: non-selector writes do not switch
    bus_write(4'h0, 32'h0);
    bus_write(4'hC, 32'h3);
    bus_write(4'h8, 32'h0);
    read_check(4'h0, "R2");
    bus_write(4'h4, 32'h0);
    bus_rd_addr = 4'h0; #1;
    check("R2", bus_rd_data, 32'd0);
    read_check(4'h8, "R6");
    // R5: get ID of CPU 9
    bus_write(4'h4, 32'd9);
    bus_write(4'hC, 32'd3);
    read_check(4'h0, "R5");
    read_check(4'h8, "R5");
    read_check(4'h4, "R10");
    // R7: invalid selector then command ignored
    bus_write(4'h4, 32'd40);
    read_check(4'h0, "R3");
    bus_write(4'hC, 32'd0);
    bus_write(4'h4, 32'd9);
    bus_rd_addr = 4'h0; #1;
    check("R7", bus_rd_data, 32'hDEAD_0009);
    // R6: wrap-around search from 20 finds 9
    bus_write(4'h4, 32'd20);
    bus_write(4'hC, 32'd0);
    bus_rd_addr = 4'h8; #1;
    check("R6", bus_rd_data, 32'd9);
    // R6: only event is selector itself -> stays
    bus_write(4'hC, 32'd0);
    read_check(4'h8, "R6");
    // R6: no events -> unchanged
    cfg_write(9, 1'b1, 1'b0, 64'hDEAD_0009_BEEF_0009);
    bus_write(4'h4, 32'd3);
    bus_write(4'hC, 32'd0);
    bus_rd_addr = 4'h8; #1;
    check("R6", bus_rd_data, 32'd3);
    // R4: other command
    bus_write(4'hC, 32'd7);
    read_check(4'h0, "R4");
    read_check(4'h8, "R8");
    read_check(4'hC, "R8");

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        cfg_write($urandom_range(0, N-1), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                  {$urandom, $urandom});
      end else if (op < 5) begin
        logic [31:0] s = ($urandom_range(0, 3) == 0) ? 32'(N + $urandom_range(0, 100))
                                                      : 32'($urandom_range(0, N-1));
        bus_write(4'h4, s);
      end else if (op < 7) begin
        int c = $urandom_range(0, 4);
        bus_write(4'hC, (c < 2) ? 32'd0 : (c < 4) ? 32'd3 : 32'($urandom_range(1, 255)));
      end else begin
        read_auto(4'($urandom_range(0, 15)));
      end
    end
    for (int a = 0; a < 16; a++) read_auto(4'(a));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule